// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block serialises data words onto a single transmit line. Software drops a word into a one-entry holding register with a write strobe. At the next baud tick after the line is free, the word moves into a shift register. It then leaves the block as a start bit, the data bits least significant first, and a stop bit. Each bit lasts exactly one period of an externally supplied baud tick. A frame-length select picks 8 or 9 data bits. The ninth bit is captured from a separate input at the moment the word is written.

A break request forces the line low. Any word already in flight or waiting in the holding register is sent before the break starts. The line then stays low for at least thirteen baud periods and for as long as the request remains set. After the break, the line is held high for at least one full bit period before anything else is sent.

The line is driven only while both the global enable and the transmitter enable are 1. Dropping either enable aborts the frame in flight, empties the holding register and releases the pin through the output-enable.

Top module: `sertx_top`

## Requirements
- R1: `tx_oe` equals `uart_en AND tx_en` in the same cycle. Whenever `tx_oe` is 0, `tx_out` reads 1.
- R2: The line idles at 1. A frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. The start bit begins in the cycle after the baud tick that finds the holding register full while the line is free. Each bit holds from one `baud_tick` to the next.
- R3: `nine_sel` is sampled when a frame starts. When it is 1, nine data bits are sent, and the ninth is the value `tx_bit8` had when the word was written. When it is 0, eight data bits are sent.
- R4: A `wr_stb` is ignored while the holding register is full. It is also ignored while the transmitter is not enabled. In both cases the word sent later is the one held before.
- R5: `buf_empty` falls in the cycle after an accepted write. It rises in the cycle after the baud tick that moves the word into the shift register.
- R6: A word written during a frame starts at the same baud tick that ends that frame's stop bit, with no idle bit in between.
- R7: With `brk_req` set, a frame in flight and a word waiting in the holding register are both sent before the line goes low.
- R8: A break starts at a baud tick and holds the line low until the first baud tick that finds `brk_req` at 0 after at least 13 bit periods have elapsed. A one-cycle request therefore gives exactly 13 bit periods of low line.
- R9: When a break ends, the line stays at 1 for at least one full bit period before the next start bit or break.
- R10: In the cycle after the transmitter is found disabled, the frame in flight and the holding register are discarded, so `buf_empty` and `tx_idle` are 1.
- R11: `tx_idle` is 1 exactly when the holding register is empty, no frame is being shifted, and neither a break nor its trailing high bit is in progress. It is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uart_en | input | 1 | Global serial-port enable |
| tx_en | input | 1 | Transmitter enable |
| nine_sel | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| tx_bit8 | input | 1 | Ninth data bit, captured with the write |
| brk_req | input | 1 | Break request |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data word to send |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_out | output | 1 | Serial line value |
| tx_oe | output | 1 | Line output-enable (0 = high impedance) |
| buf_empty | output | 1 | Holding register empty |
| tx_idle | output | 1 | Nothing queued, shifting or breaking |

## Verification
`tx_oe` follows the enables in the same cycle, with no register on the way. Every other result is due one clock after the edge that causes it. The line and `buf_empty` change in the cycle after the deciding baud tick, and `buf_empty` falls one cycle after an accepted write. The abort state is visible one cycle after the enable is seen low. The bench's reference model advances on the same rising edge as the design, and all four outputs are compared a quarter period later, in every cycle. A separate run-length counter confirms that a one-cycle break request holds the line low for exactly thirteen baud periods.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes nothing beyond the standard language.
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_BREAK = 2'd2,
        ST_GUARD = 2'd3
    } sertx_state_e;
endpackage

// File: rtl/sertx_holdbuf.sv
// One-entry holding register between the software write port and the framer.
// Assumes the framer asserts take only while full is 1.
module sertx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    input  logic              take,
    output logic              full,
    output logic [DATA_W:0]   word
);
    // Capture a word when empty, release it when the framer takes it, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            full <= 1'b0;
            word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            word <= {wr_bit8, wr_data};
        end
    end

    assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_stb && !full) |=> full);
    assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && full && !take) |=> $stable(word));
endmodule

// File: rtl/sertx_brktimer.sv
// Counts baud ticks spent in a break and flags when the minimum length is reached.
// Assumes in_break is held by the framer for the whole break.
module sertx_brktimer #(
    parameter int MIN_BITS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic in_break,
    input  logic tick,
    output logic min_done
);
    localparam int CW = (MIN_BITS > 1) ? $clog2(MIN_BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_BITS - 1);

    logic [CW-1:0] cnt;

    // Count ticks inside a break, saturating at the last required bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !in_break) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign min_done = (cnt == LAST);

    assert_brk_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && in_break && tick && !min_done) |=> in_break);
endmodule

// File: rtl/sertx_framer.sv
// Frame sequencer: loads words, shifts start/data/stop bits, runs break and guard bits.
// Assumes tick is a single-cycle pulse per bit period and buf_word is valid while buf_full.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              nine_sel,
    input  logic              brk_req,
    input  logic              buf_full,
    input  logic [DATA_W:0]   buf_word,
    input  logic              min_done,
    output logic              take,
    output logic              line,
    output sertx_state_e      state
);
    localparam int FW   = DATA_W + 3;
    localparam int CNTW = $clog2(FW + 1);

    sertx_state_e    st_n;
    logic [FW-1:0]   sh;
    logic [CNTW-1:0] left;
    logic            decide;

    // A decision point is a tick where the line is free: idle, guard, or last stop bit.
    assign decide = tick && ((state == ST_IDLE) || (state == ST_GUARD) ||
                             (state == ST_SHIFT && left == CNTW'(1)));
    assign take   = run && decide && buf_full;

    // Next-state choice: queued data first, then break, else idle.
    always_comb begin
        st_n = state;
        if (decide) begin
            if (buf_full)     st_n = ST_SHIFT;
            else if (brk_req) st_n = ST_BREAK;
            else              st_n = ST_IDLE;
        end else if (state == ST_BREAK && tick && min_done && !brk_req) begin
            st_n = ST_GUARD;
        end
    end

    // State register, cleared by reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) state <= ST_IDLE;
        else                state <= st_n;
    end

    // Shift register and bit counter: load a frame on take, shift on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sh   <= '1;
            left <= '0;
        end else if (take) begin
            if (nine_sel) begin
                sh   <= {1'b1, buf_word[DATA_W], buf_word[DATA_W-1:0], 1'b0};
                left <= CNTW'(FW);
            end else begin
                sh   <= {2'b11, buf_word[DATA_W-1:0], 1'b0};
                left <= CNTW'(FW - 1);
            end
        end else if (tick && state == ST_SHIFT) begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
        end
    end

    // Line value from the current state.
    always_comb begin
        case (state)
            ST_SHIFT: line = sh[0];
            ST_BREAK: line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line == 1'b0));
    assert_data_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_SHIFT && left == CNTW'(1) && tick && buf_full) |=> (state == ST_SHIFT));
    assert_guard_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_BREAK && $past(state) == ST_BREAK) |-> (line == 1'b0));
    assert_guard_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_GUARD) |-> (line == 1'b1));
endmodule

// File: rtl/sertx_top.sv
// Serial transmitter top: holding register, framer and break timer, plus pin gating.
// Assumes baud_tick comes from an external divider at one pulse per bit.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BRK  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_en,
    input  logic              tx_en,
    input  logic              nine_sel,
    input  logic              tx_bit8,
    input  logic              brk_req,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              tx_out,
    output logic              tx_oe,
    output logic              buf_empty,
    output logic              tx_idle
);
    logic            run;
    logic            take;
    logic            full;
    logic [DATA_W:0] word;
    logic            line;
    logic            min_done;
    sertx_state_e    state;

    assign run = uart_en & tx_en;

    sertx_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_bit8(tx_bit8), .take(take), .full(full), .word(word)
    );

    sertx_framer #(.DATA_W(DATA_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(baud_tick), .nine_sel(nine_sel),
        .brk_req(brk_req), .buf_full(full), .buf_word(word), .min_done(min_done),
        .take(take), .line(line), .state(state)
    );

    sertx_brktimer #(.MIN_BITS(MIN_BRK)) u_brk (
        .clk(clk), .rst_n(rst_n), .run(run), .in_break(state == ST_BREAK),
        .tick(baud_tick), .min_done(min_done)
    );

    // Pin gating and status flags.
    assign tx_oe     = run;
    assign tx_out    = run ? line : 1'b1;
    assign buf_empty = !full;
    assign tx_idle   = !full && (state == ST_IDLE);

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (buf_empty && tx_idle));
    assert_idle_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_out);
endmodule

// File: tb/sertx_top_bench.sv
module sertx_top_bench;
    localparam int CLK_P = 10;
    localparam int DIV   = 4;
    localparam int DW    = 8;
    localparam int MINB  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_en = 1'b1, tx_en = 1'b1, nine_sel = 1'b0, tx_bit8 = 1'b0, brk_req = 1'b0;
    logic wr_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic baud_tick = 1'b0;
    logic tx_out, tx_oe, buf_empty, tx_idle;

    int errors = 0, checks = 0;
    string phase = "R11";
    bit finished = 0;

    sertx_top #(.DATA_W(DW), .MIN_BRK(MINB)) u_sertx_top (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .tx_en(tx_en), .nine_sel(nine_sel),
        .tx_bit8(tx_bit8), .brk_req(brk_req), .wr_stb(wr_stb), .wr_data(wr_data),
        .baud_tick(baud_tick), .tx_out(tx_out), .tx_oe(tx_oe), .buf_empty(buf_empty),
        .tx_idle(tx_idle)
    );

    always #(CLK_P/2) clk = ~clk;

    // Baud tick: one pulse every DIV clocks.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % DIV;
        baud_tick = (tdiv == DIV - 1);
    end

    // Reference model state.
    bit m_q[$];
    bit m_full = 0;
    logic [DW:0] m_word = '0;
    bit m_brk = 0, m_guard = 0;
    int m_cnt = 0;

    task automatic m_decide();
        if (m_full) begin
            m_q.push_back(1'b0);
            for (int i = 0; i < DW; i++) m_q.push_back(m_word[i]);
            if (nine_sel) m_q.push_back(m_word[DW]);
            m_q.push_back(1'b1);
            m_full = 0;
            m_guard = 0;
        end else if (brk_req) begin
            m_brk = 1; m_cnt = 0; m_guard = 0;
        end else begin
            m_guard = 0;
        end
    endtask

    always @(posedge clk) begin
        bit was_full;
        was_full = m_full;
        if (!rst_n || !(uart_en && tx_en)) begin
            m_q.delete(); m_full = 0; m_word = '0; m_brk = 0; m_guard = 0; m_cnt = 0;
        end else begin
            if (baud_tick) begin
                if (m_q.size() > 0) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_decide();
                end else if (m_brk) begin
                    if (m_cnt == MINB - 1 && !brk_req) begin
                        m_brk = 0; m_guard = 1;
                    end else if (m_cnt < MINB - 1) m_cnt++;
                end else begin
                    m_decide();
                end
            end
            if (wr_stb && !was_full) begin
                m_full = 1; m_word = {tx_bit8, wr_data};
            end
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Low-run monitor for the break-length check.
    int low_run = 0, last_low = 0;

    // Compare every cycle a quarter period after the rising edge.
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (!finished) begin
            logic run, e_line, e_idle;
            run = uart_en && tx_en;
            e_line = !run ? 1'b1 : (m_q.size() > 0) ? m_q[0] : (m_brk ? 1'b0 : 1'b1);
            e_idle = !m_full && m_q.size() == 0 && !m_brk && !m_guard;
            chk("R1", "tx_oe", tx_oe, run);
            chk(phase, "tx_out", tx_out, e_line);
            chk("R5", "buf_empty", buf_empty, !m_full);
            chk("R11", "tx_idle", tx_idle, e_idle);
            if (tx_out == 1'b0) low_run++;
            else begin
                if (low_run > 0) last_low = low_run;
                low_run = 0;
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(logic [DW-1:0] d, logic b8);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; tx_bit8 = b8;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R11", "reset tx_idle", tx_idle, 1'b1);
        chk("R11", "reset buf_empty", buf_empty, 1'b1);
        chk("R2", "reset idle line", tx_out, 1'b1);

        phase = "R2";
        put(8'hA5, 1'b0);
        cyc(60);

        phase = "R3";
        nine_sel = 1'b1;
        put(8'h3C, 1'b1);
        cyc(60);
        put(8'hFF, 1'b0);
        cyc(60);
        nine_sel = 1'b0;

        phase = "R6";
        put(8'h81, 1'b0);
        cyc(8);
        put(8'h5A, 1'b0);
        phase = "R4";
        put(8'h00, 1'b0);
        cyc(120);

        phase = "R7";
        put(8'hC3, 1'b0);
        cyc(6);
        put(8'h0F, 1'b0);
        brk_req = 1'b1;
        cyc(200);
        brk_req = 1'b0;
        cyc(30);

        phase = "R8";
        cyc(3);
        brk_req = 1'b1;
        cyc(1);
        brk_req = 1'b0;
        cyc(80);
        checks++;
        if (last_low != MINB * DIV) begin
            errors++;
            $display("FAIL R8 break low cycles actual=%0d expected=%0d", last_low, MINB * DIV);
        end

        phase = "R9";
        brk_req = 1'b1;
        cyc(20);
        put(8'h66, 1'b0);
        cyc(60);
        brk_req = 1'b0;
        cyc(70);

        phase = "R10";
        put(8'hE7, 1'b0);
        cyc(3);
        put(8'h18, 1'b0);
        cyc(12);
        tx_en = 1'b0;
        cyc(1);
        chk("R10", "tx_oe released", tx_oe, 1'b0);
        put(8'h99, 1'b0);
        cyc(2);
        tx_en = 1'b1;
        cyc(20);

        phase = "R1";
        put(8'h42, 1'b0);
        cyc(10);
        uart_en = 1'b0;
        cyc(3);
        chk("R1", "pin reads high when released", tx_out, 1'b1);
        uart_en = 1'b1;
        cyc(60);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule